// File: doc/BRIEF.md
# Page-Bounded Flash Transfer Splitter

This block sits between a host that wants to move an arbitrary run of bytes to or from serial flash and a flash controller that only handles one bounded command at a time. The host hands over a start address, a byte count and a direction. The block cuts the run into controller-sized pieces and drives the controller through its register port, one access at a time, for each piece.

Read pieces are limited only by the size of the controller's data buffer. Write pieces are also kept inside a single program page, so a write never wraps inside a page. The first write piece is therefore often short: it runs from the start address to the end of that page.

Payload bytes move over two ready/valid byte streams: one carries bytes from the host for writes, the other carries bytes to the host for reads. A one-cycle done pulse closes each request. An error flag on that pulse marks a request that was refused without any register traffic.

Top module: `page_splitter`

## Requirements
- R1: A read piece carries min(remaining bytes, BUF_BYTES) bytes (256 by default). Its length appears in bits [15:0] of the command word, and opcode 0x03 appears in bits [23:16].
- R2: A write piece carries PAGE_BYTES minus the address bits below the page size, capped by the remaining count. Its command word has opcode 0x02 in bits [23:16] and the length in bits [15:0].
- R3: For each read piece the register accesses come in this order: a write of the flash address to offset 0x004, a write of the command word to offset 0x008, reads of offset 0x00C until bit 0 is set, then one read per byte at offset 0x100+i for i from 0 upward. Bits [7:0] of each buffer read leave on the output stream in order, and the upper bits are dropped.
- R4: For each write piece the block first takes the piece's bytes from the input stream in order and writes byte i to offset 0x100+i (data in bits [7:0], upper bits zero). It then writes the address to 0x004 and the command word to 0x008, and reads 0x00C until bit 0 is set.
- R5: After each piece the flash address advances by the piece length and the remaining count drops by the same amount. The request ends when the count reaches zero.
- R6: A request with zero length raises done, with the error flag low, on the cycle after it is accepted, and makes no register access.
- R7: A request whose start address plus length exceeds 2^32 raises done together with the error flag on the cycle after it is accepted, and makes no register access. A request ending exactly at 2^32 is accepted.
- R8: After the final status read that shows bit 0 set, done is high for exactly one cycle. No register access follows until a new request arrives.
- R9: The register request holds its write enable, offset and write data steady until the register port acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_write | input | 1 | 1 = write to flash, 0 = read from flash |
| req_addr | input | ADDR_W | Start flash byte address |
| req_len | input | LEN_W | Total byte count |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Qualifies done: request refused |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = register write, 0 = register read |
| reg_addr | output | 12 | Register offset |
| reg_wdata | output | 32 | Register write data |
| reg_ack | input | 1 | Access accepted this cycle |
| reg_rdata | input | 32 | Read data, valid with reg_ack |
| in_valid | input | 1 | Write payload byte present |
| in_data | input | 8 | Write payload byte |
| in_ready | output | 1 | Block takes a payload byte |
| out_valid | output | 1 | Read payload byte present |
| out_data | output | 8 | Read payload byte |
| out_ready | input | 1 | Host takes a read payload byte |

## Verification
The assertions rely on several assumptions about the environment. The register port raises its acknowledge only while a request is present, and returns read data in that same cycle. The host keeps each request's fields steady while it is offered. Address plus length wraps only in requests that the overflow check turns away. The bench stays within these limits by building its register responder so that it acknowledges only an access that is visible at that moment, with a variable wait before each acknowledge. It changes its request fields only away from the clock edge and stops offering a request once the request has been taken. Its stream pacing stalls the input and output bytes in a fixed pattern, so the hold-while-stalled properties get exercised.

// File: rtl/ps_pkg.sv
package ps_pkg;

    // Register map of the controller side, 12-bit offset space
    localparam logic [11:0] OFF_ADDR = 12'h004;
    localparam logic [11:0] OFF_CMD  = 12'h008;
    localparam logic [11:0] OFF_STAT = 12'h00C;
    localparam logic [11:0] OFF_BUF  = 12'h100;

    localparam logic [7:0]  OP_READ  = 8'h03;
    localparam logic [7:0]  OP_WRITE = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL_GET,
        ST_FILL_PUT,
        ST_ADDR,
        ST_CMD,
        ST_POLL,
        ST_DRAIN_GET,
        ST_DRAIN_PUT,
        ST_NEXT
    } seq_state_e;

endpackage

// File: rtl/ps_chunk.sv
module ps_chunk #(
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned PAGE_BYTES = 256,
    parameter int unsigned BUF_BYTES  = 256,
    parameter int unsigned PW         = $clog2(PAGE_BYTES),
    parameter int unsigned CW         = 9
) (
    input  logic [PW-1:0]    addr_lo,
    input  logic [LEN_W-1:0] rem,
    input  logic             is_write,
    output logic [CW-1:0]    chunk
);

    logic [CW-1:0] page_room;
    logic [CW-1:0] limit;

    // Bytes left before the next page edge (whole page when aligned)
    assign page_room = CW'(PAGE_BYTES) - CW'(addr_lo);

    // Reads are only bounded by the buffer, writes also by the page
    assign limit = is_write ? page_room : CW'(BUF_BYTES);

    always_comb begin
        if (rem < LEN_W'(limit)) begin
            chunk = CW'(rem);
        end else begin
            chunk = limit;
        end
    end

endmodule

// File: rtl/ps_cursor.sv
module ps_cursor #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 32,
    parameter int unsigned CW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              adv,
    input  logic [CW-1:0]     step,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  rem
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (load) begin
            cur_d.addr = ld_addr;
            cur_d.rem  = ld_len;
        end else if (adv) begin
            cur_d.addr = cur_q.addr + ADDR_W'(step);
            cur_d.rem  = cur_q.rem - LEN_W'(step);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign addr = cur_q.addr;
    assign rem  = cur_q.rem;

    // End of the run (address plus remaining) is invariant while advancing
    logic [ADDR_W-1:0] run_end;
    assign run_end = cur_q.addr + ADDR_W'(cur_q.rem);

    a_r5_end_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load |=> run_end == $past(run_end));

    a_r5_step_fits: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (step != '0) && (LEN_W'(step) <= cur_q.rem));

    a_r5_rem_drops: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load |=> cur_q.rem < $past(cur_q.rem));

endmodule

// File: rtl/ps_seq.sv
module ps_seq
    import ps_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned PAGE_BYTES = 256,
    parameter int unsigned BUF_BYTES  = 256,
    parameter int unsigned PW         = $clog2(PAGE_BYTES),
    parameter int unsigned CW         = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    // host request
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              done,
    output logic              done_err,
    // cursor and sizer
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  cur_rem,
    input  logic [CW-1:0]     chunk,
    output logic              cur_load,
    output logic              cur_adv,
    output logic              is_write,
    // register master
    output logic              reg_req,
    output logic              reg_we,
    output logic [11:0]       reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata,
    // payload streams
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready
);

    typedef struct packed {
        seq_state_e    state;
        logic          is_wr;
        logic [CW-1:0] idx;
        logic [7:0]    data;
        logic          done;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;

    logic [ADDR_W:0] req_end;
    logic            req_ovf;
    logic            idx_last;
    logic            piece_last;
    logic [7:0]      opcode;
    logic [22:0]     unused_rdata_hi;

    assign unused_rdata_hi = reg_rdata[31:9];

    // End of run one past the last byte; beyond 2^ADDR_W is refused
    assign req_end    = {1'b0, req_addr} + (ADDR_W+1)'(req_len);
    assign req_ovf    = req_end[ADDR_W] && (req_end[ADDR_W-1:0] != '0);
    assign idx_last   = (s_q.idx == chunk - CW'(1));
    assign piece_last = (cur_rem == LEN_W'(chunk));
    assign opcode     = s_q.is_wr ? OP_WRITE : OP_READ;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.err   = 1'b0;

        req_ready = 1'b0;
        cur_load  = 1'b0;
        cur_adv   = 1'b0;
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        in_ready  = 1'b0;
        out_valid = 1'b0;

        unique case (s_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (req_ovf) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else if (req_len == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        cur_load  = 1'b1;
                        s_d.is_wr = req_write;
                        s_d.idx   = '0;
                        s_d.state = req_write ? ST_FILL_GET : ST_ADDR;
                    end
                end
            end

            ST_FILL_GET: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    s_d.data  = in_data;
                    s_d.state = ST_FILL_PUT;
                end
            end

            ST_FILL_PUT: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = OFF_BUF + 12'(s_q.idx);
                reg_wdata = {24'h0, s_q.data};
                if (reg_ack) begin
                    if (idx_last) begin
                        s_d.idx   = '0;
                        s_d.state = ST_ADDR;
                    end else begin
                        s_d.idx   = s_q.idx + CW'(1);
                        s_d.state = ST_FILL_GET;
                    end
                end
            end

            ST_ADDR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = OFF_ADDR;
                reg_wdata = 32'(cur_addr);
                if (reg_ack) begin
                    s_d.state = ST_CMD;
                end
            end

            ST_CMD: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = OFF_CMD;
                reg_wdata = {8'h00, opcode, 16'(chunk)};
                if (reg_ack) begin
                    s_d.state = ST_POLL;
                end
            end

            ST_POLL: begin
                reg_req  = 1'b1;
                reg_addr = OFF_STAT;
                if (reg_ack && reg_rdata[0]) begin
                    s_d.idx   = '0;
                    s_d.state = s_q.is_wr ? ST_NEXT : ST_DRAIN_GET;
                end
            end

            ST_DRAIN_GET: begin
                reg_req  = 1'b1;
                reg_addr = OFF_BUF + 12'(s_q.idx);
                if (reg_ack) begin
                    s_d.data  = reg_rdata[7:0];
                    s_d.state = ST_DRAIN_PUT;
                end
            end

            ST_DRAIN_PUT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (idx_last) begin
                        s_d.idx   = '0;
                        s_d.state = ST_NEXT;
                    end else begin
                        s_d.idx   = s_q.idx + CW'(1);
                        s_d.state = ST_DRAIN_GET;
                    end
                end
            end

            ST_NEXT: begin
                cur_adv = 1'b1;
                s_d.idx = '0;
                if (piece_last) begin
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.state = s_q.is_wr ? ST_FILL_GET : ST_ADDR;
                end
            end

            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, is_wr: 1'b0, idx: '0, data: '0,
                     done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = s_q.done;
    assign done_err = s_q.err;
    assign is_write = s_q.is_wr;
    assign out_data = s_q.data;

    // ---------------------------------------------------------------
    // Checks next to the logic
    // ---------------------------------------------------------------
    logic cmd_issue;
    logic [CW:0] page_fill;
    assign cmd_issue = reg_req && reg_we && (reg_addr == OFF_CMD);
    assign page_fill = (CW+1)'(cur_addr[PW-1:0]) + (CW+1)'(reg_wdata[CW-1:0]);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> reg_req && $stable(reg_we)
                                && $stable(reg_addr) && $stable(reg_wdata));

    a_r1_read_len: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue && reg_wdata[23:16] == OP_READ |->
            reg_wdata[15:0] != 16'h0 && reg_wdata[15:0] <= 16'(BUF_BYTES)
            && 32'(reg_wdata[15:0]) <= 32'(cur_rem));

    a_r2_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue && reg_wdata[23:16] == OP_WRITE |->
            reg_wdata[15:0] != 16'h0 && page_fill <= (CW+1)'(PAGE_BYTES));

    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_len == '0 |=> done && !done_err);

    a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_ovf |=> done && done_err && !reg_req);

    a_r8_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !reg_req && !in_ready && !out_valid);

endmodule

// File: rtl/page_splitter.sv
module page_splitter #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned PAGE_BYTES = 256,
    parameter int unsigned BUF_BYTES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              done,
    output logic              done_err,
    output logic              reg_req,
    output logic              reg_we,
    output logic [11:0]       reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready
);

    localparam int unsigned MAX_PIECE = (PAGE_BYTES > BUF_BYTES) ? PAGE_BYTES : BUF_BYTES;
    localparam int unsigned CW        = $clog2(MAX_PIECE) + 1;
    localparam int unsigned PW        = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_rem;
    logic [CW-1:0]     chunk;
    logic              cur_load;
    logic              cur_adv;
    logic              is_write;

    ps_cursor #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CW     (CW)
    ) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cur_load),
        .ld_addr (req_addr),
        .ld_len  (req_len),
        .adv     (cur_adv),
        .step    (chunk),
        .addr    (cur_addr),
        .rem     (cur_rem)
    );

    ps_chunk #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BUF_BYTES  (BUF_BYTES),
        .PW         (PW),
        .CW         (CW)
    ) u_chunk (
        .addr_lo  (cur_addr[PW-1:0]),
        .rem      (cur_rem),
        .is_write (is_write),
        .chunk    (chunk)
    );

    ps_seq #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BUF_BYTES  (BUF_BYTES),
        .PW         (PW),
        .CW         (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .done      (done),
        .done_err  (done_err),
        .cur_addr  (cur_addr),
        .cur_rem   (cur_rem),
        .chunk     (chunk),
        .cur_load  (cur_load),
        .cur_adv   (cur_adv),
        .is_write  (is_write),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

endmodule

// File: tb/page_splitter_bench.sv
`timescale 1ns/1ps
module page_splitter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        done;
    logic        done_err;
    logic        reg_req;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ack = 1'b0;
    logic [31:0] reg_rdata = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;

    always #5 clk = ~clk;

    page_splitter u_page_splitter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .done      (done),
        .done_err  (done_err),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_ack   (reg_ack),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    typedef struct {
        bit        we;
        bit [11:0] addr;
        bit [31:0] wdata;
        string     tag;
    } acc_t;

    acc_t     exp_q[$];
    bit [7:0] exp_out[$];
    string    out_tag[$];
    bit [7:0] feed_q[$];

    int  n_chk  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    int  acc_seen = 0;
    int  wait_cnt = 0;
    int  polls    = 0;
    bit  in_pend  = 1'b0;
    bit  finished = 1'b0;
    bit [31:0] flash_addr = '0;
    bit [7:0]  feed_seq = 8'h11;

    function automatic bit [7:0] pat(bit [31:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Register responder and access scoreboard
    always @(negedge clk) begin
        reg_ack   = 1'b0;
        reg_rdata = '0;
        if (rst_n && reg_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                reg_ack = 1'b1;
                acc_seen++;
                wait_cnt = acc_seen % 3;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected register access at offset", reg_addr, 0);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    check(e.we == reg_we && e.addr == reg_addr
                          && (!e.we || e.wdata == reg_wdata), e.tag,
                          "access {we,offset,wdata}",
                          {reg_we, reg_addr, reg_wdata}, {e.we, e.addr, e.wdata});
                end
                if (reg_we && reg_addr == 12'h004) flash_addr = reg_wdata;
                if (reg_we && reg_addr == 12'h008) polls = 0;
                if (!reg_we && reg_addr == 12'h00C) begin
                    polls++;
                    reg_rdata = (polls >= 2) ? 32'hFFFF_FFF1 : 32'hFFFF_FFF0;
                end
                if (!reg_we && reg_addr >= 12'h100)
                    reg_rdata = {24'hA5A5A5, pat(flash_addr + 32'(reg_addr - 12'h100))};
            end
        end
    end

    // Read stream monitor
    always @(negedge clk) begin
        out_ready = (cyc % 5) != 4;
        if (rst_n && out_valid && out_ready) begin
            if (exp_out.size() == 0) begin
                check(1'b0, "R3", "unexpected output byte", out_data, 0);
            end else begin
                bit [7:0] eb;
                string    t;
                eb = exp_out.pop_front();
                t  = out_tag.pop_front();
                check(out_data == eb, t, "output byte", out_data, eb);
            end
        end
    end

    // Write stream feeder
    always @(negedge clk) begin
        if (in_pend) void'(feed_q.pop_front());
        in_valid = (feed_q.size() > 0) && ((cyc % 4) != 1);
        in_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
        in_pend  = in_valid && in_ready;
    end

    // Driver: predicts the whole access sequence, then issues the request
    task automatic run_req(bit wr, bit [31:0] a, bit [31:0] n, bit exp_err, string tag);
        bit [31:0] cur;
        bit [31:0] rem;
        bit [31:0] lim;
        bit [31:0] ch;
        int        waited;
        int        acc_before;
        cur = a;
        rem = exp_err ? 32'd0 : n;
        while (rem > 0) begin
            lim = wr ? (32'd256 - {24'h0, cur[7:0]}) : 32'd256;
            ch  = (rem < lim) ? rem : lim;
            if (wr) begin
                for (int i = 0; i < int'(ch); i++) begin
                    feed_q.push_back(feed_seq);
                    exp_q.push_back('{1'b1, 12'h100 + 12'(i), {24'h0, feed_seq}, "R4"});
                    feed_seq = feed_seq + 8'd13;
                end
            end
            exp_q.push_back('{1'b1, 12'h004, cur, "R5"});
            exp_q.push_back('{1'b1, 12'h008,
                              {8'h00, (wr ? 8'h02 : 8'h03), ch[15:0]},
                              wr ? "R2" : "R1"});
            exp_q.push_back('{1'b0, 12'h00C, 32'h0, wr ? "R4" : "R3"});
            exp_q.push_back('{1'b0, 12'h00C, 32'h0, wr ? "R4" : "R3"});
            if (!wr) begin
                for (int i = 0; i < int'(ch); i++) begin
                    exp_q.push_back('{1'b0, 12'h100 + 12'(i), 32'h0, "R3"});
                    exp_out.push_back(pat(cur + 32'(i)));
                    out_tag.push_back("R3");
                end
            end
            cur = cur + ch;
            rem = rem - ch;
        end

        acc_before = acc_seen;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_len   = n;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done && waited < 30000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, tag, "done raised", done, 1);
        check(done_err == exp_err, exp_err ? "R7" : tag, "done_err", done_err, exp_err);
        check(exp_q.size() == 0, tag, "predicted accesses left", exp_q.size(), 0);
        check(exp_out.size() == 0, "R3", "predicted output bytes left", exp_out.size(), 0);
        check(feed_q.size() == 0, "R4", "input bytes not taken", feed_q.size(), 0);
        if (n == 0 || exp_err)
            check(acc_seen == acc_before, exp_err ? "R7" : "R6",
                  "register accesses made", acc_seen - acc_before, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width beyond one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(reg_req == 1'b0, "R8", "register request after done", reg_req, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R8", "watchdog expired at cycle", cyc, 150000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(req_ready == 1'b1, "R8", "req_ready after reset", req_ready, 1);
        check(done == 1'b0, "R8", "done after reset", done, 0);
        check(reg_req == 1'b0, "R9", "reg_req after reset", reg_req, 0);
        check(out_valid == 1'b0 && in_ready == 1'b0, "R3", "streams idle after reset",
              {out_valid, in_ready}, 0);

        run_req(1'b0, 32'h0000_1000, 32'd10,  1'b0, "R1");   // short read
        run_req(1'b0, 32'h0000_0020, 32'd600, 1'b0, "R5");   // 256+256+88
        run_req(1'b1, 32'h0000_10F0, 32'd40,  1'b0, "R2");   // 16+24
        run_req(1'b1, 32'h0000_2000, 32'd256, 1'b0, "R2");   // exactly one page
        run_req(1'b1, 32'h0000_30FF, 32'd300, 1'b0, "R5");   // 1+256+43
        run_req(1'b0, 32'h0000_5000, 32'd0,   1'b0, "R6");   // zero length
        run_req(1'b1, 32'hFFFF_FF00, 32'h101, 1'b1, "R7");   // past 2^32
        run_req(1'b0, 32'hFFFF_FF80, 32'h80,  1'b0, "R7");   // ends exactly at 2^32
        run_req(1'b0, 32'h0000_0007, 32'd257, 1'b0, "R1");   // 256+1, unaligned read
        run_req(1'b1, 32'h0000_0000, 32'd0,   1'b0, "R6");   // zero-length write

        finished = 1'b1;
        summary();
    end

endmodule